// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM's cells alive without help from software. A free-running timer derived from the system clock produces one refresh request per interval. The interval is the retention window divided by the number of rows (2^ROW_W). Requests that cannot be served at once are held in a small saturating pending counter.

When at least one request is pending and the block is idle, it raises `req_o` toward the access controller. `gnt_i` acts as the ready side of a valid/ready pair. `req_o` never drops until a cycle in which `gnt_i` is sampled high, and a high `gnt_i` does nothing while `req_o` is low. Once granted, the block owns the DRAM strobes. It works off every pending request back to back, including requests that arrive during the burst, without asking again.

Two refresh styles are offered, chosen per cycle by `ras_only_i`:

- **CAS-before-RAS:** the device counts rows itself, so the address is not driven.
- **RAS-only:** the block presents its own row counter on the address pins.

All timings are parameters in clock cycles. The precharge time is the larger of `T_RP` and `T_CP`.

Top module: `rfsh_sched`

## Requirements
- R1: A request is produced every INTERVAL = WINDOW_CYC / 2^ROW_W clock cycles. With `gnt_i` held high and the mode unchanged, consecutive RAS falls are exactly INTERVAL cycles apart.
- R2: In CAS-before-RAS mode (`ras_only_i`=0), `cas_n_o` falls exactly T_CSR cycles before `ras_n_o` falls. `cas_n_o` stays low for the whole RAS-low phase, and `addr_en_o` stays 0.
- R3: While the block is busy, `we_n_o` and `oe_n_o` stay high, so the DRAM never drives its data pins during refresh.
- R4: In RAS-only mode (`ras_only_i`=1), `addr_en_o` is 1 and `cas_n_o` is 1 while RAS is low, and `row_addr_o` carries the row counter. The counter is 0 after reset and advances by one, wrapping modulo 2^ROW_W, after each RAS-only cycle only.
- R5: `ras_n_o` stays low for exactly T_RAS cycles per refresh.
- R6: After RAS rises, both strobes stay high for T_PRE = max(T_RP, T_CP) cycles before the next refresh starts or the bus is released. CAS is never high for fewer than T_CP cycles before it falls again.
- R7: `req_o` is high exactly when a request is pending and the block is idle. Once high, it stays high until `gnt_i` is sampled high.
- R8: The pending count saturates at PEND_MAX (default 8), and excess requests are dropped. After a grant, all pending requests run back to back in a single busy period.
- R9: `busy_o` rises in the cycle after the grant and falls after the last precharge. While `busy_o` is low, both strobes are high. While `busy_o` is high, `req_o` is low.
- R10: During reset, `ras_n_o`, `cas_n_o`, `we_n_o` and `oe_n_o` are 1, and `req_o`, `busy_o` and `addr_en_o` are 0.
- R11: The mode is sampled when each refresh cycle starts. A change during a cycle only affects the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_only_i | input | 1 | 1 selects RAS-only refresh, 0 selects CAS-before-RAS |
| gnt_i | input | 1 | Grant (ready) from the access controller |
| req_o | output | 1 | Refresh request (valid) to the access controller |
| busy_o | output | 1 | Block owns the DRAM strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low, held high |
| oe_n_o | output | 1 | Output enable, active low, held high |
| row_addr_o | output | ROW_W | Row address for RAS-only refresh |
| addr_en_o | output | 1 | Address pins must carry `row_addr_o` |

## Verification
**Grant timing.** A grant sampled at edge E moves `busy_o` high after E. RAS falls at E in RAS-only mode and T_CSR edges later in CAS-before-RAS mode.

**Cycle phases.** RAS stays low for T_RAS edges. `busy_o` falls T_PRE edges after RAS rises, unless another request is pending. Every output is sampled on the falling clock edge, and inputs change just after the rising edge. Run lengths are counted in falling-edge samples, so each phase width is compared against the exact cycle count from the requirements.

**Request bursts.** Request bursts are produced by withholding the grant for a known number of intervals, timed from the rise of `req_o`. The grant is then given with half an interval to spare, so the expected burst length is exact.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CAS_LEAD,
    ST_RAS_LOW,
    ST_PRECHG
  } rfsh_state_e;
endpackage

// File: rtl/rfsh_tick.sv
module rfsh_tick #(
  parameter int INTERVAL = 1562
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/rfsh_pend.sv
module rfsh_pend #(
  parameter int PEND_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic dec_i,
  output logic has_o
);
  localparam int PW = $clog2(PEND_MAX + 1);
  localparam logic [PW-1:0] CAP = PW'(PEND_MAX);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (cnt_q != CAP) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign has_o = (cnt_q != '0);
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsh_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int T_CSR = 2,
  parameter int T_RAS = 6,
  parameter int T_PRE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             has_pend_i,
  input  logic             gnt_i,
  input  logic             mode_ro_i,
  output logic             take_o,
  output logic             req_o,
  output logic             busy_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic [ROW_W-1:0] row_o,
  output logic             addr_en_o
);
  localparam int TMAX = (T_CSR > T_RAS) ? ((T_CSR > T_PRE) ? T_CSR : T_PRE)
                                        : ((T_RAS > T_PRE) ? T_RAS : T_PRE);
  localparam int CW = $clog2(TMAX + 1);
  localparam logic [CW-1:0] CSR_END = CW'(T_CSR - 1);
  localparam logic [CW-1:0] RAS_END = CW'(T_RAS - 1);
  localparam logic [CW-1:0] PRE_END = CW'(T_PRE - 1);

  rfsh_state_e     st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            ro_q, ro_d;
  logic [ROW_W-1:0] row_q;
  logic            ras_n_q, cas_n_q, aen_q;
  logic            take;

  always_comb begin
    st_d = st_q;
    take = 1'b0;
    unique case (st_q)
      ST_IDLE: if (has_pend_i && gnt_i) take = 1'b1;
      ST_CAS_LEAD: if (cnt_q == CSR_END) st_d = ST_RAS_LOW;
      ST_RAS_LOW:  if (cnt_q == RAS_END) st_d = ST_PRECHG;
      ST_PRECHG: begin
        if (cnt_q == PRE_END) begin
          if (has_pend_i) take = 1'b1;
          else            st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    ro_d = take ? mode_ro_i : ro_q;
    if (take) st_d = mode_ro_i ? ST_RAS_LOW : ST_CAS_LEAD;
    cnt_d = (st_d != st_q) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      ro_q    <= 1'b0;
      row_q   <= '0;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
      aen_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      ro_q    <= ro_d;
      if (st_q == ST_RAS_LOW && st_d == ST_PRECHG && ro_q) row_q <= row_q + 1'b1;
      ras_n_q <= (st_d != ST_RAS_LOW);
      cas_n_q <= !((st_d == ST_CAS_LEAD) || (st_d == ST_RAS_LOW && !ro_d));
      aen_q   <= (st_d == ST_RAS_LOW) && ro_d;
    end
  end

  assign take_o    = take;
  assign req_o     = has_pend_i && (st_q == ST_IDLE);
  assign busy_o    = (st_q != ST_IDLE);
  assign ras_n_o   = ras_n_q;
  assign cas_n_o   = cas_n_q;
  assign row_o     = row_q;
  assign addr_en_o = aen_q;
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
  parameter int ROW_W      = 10,
  parameter int WINDOW_CYC = 1_600_000,
  parameter int PEND_MAX   = 8,
  parameter int T_CSR      = 2,
  parameter int T_RAS      = 6,
  parameter int T_RP       = 4,
  parameter int T_CP       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_only_i,
  input  logic             gnt_i,
  output logic             req_o,
  output logic             busy_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic             oe_n_o,
  output logic [ROW_W-1:0] row_addr_o,
  output logic             addr_en_o
);
  localparam int ROWS     = 1 << ROW_W;
  localparam int INTERVAL = WINDOW_CYC / ROWS;
  localparam int T_PRE    = (T_RP > T_CP) ? T_RP : T_CP;

  logic tick, take, has_pend;

  rfsh_tick #(.INTERVAL(INTERVAL)) tick_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  rfsh_pend #(.PEND_MAX(PEND_MAX)) pend_i (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (tick),
    .dec_i (take),
    .has_o (has_pend)
  );

  rfsh_seq #(
    .ROW_W (ROW_W),
    .T_CSR (T_CSR),
    .T_RAS (T_RAS),
    .T_PRE (T_PRE)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .has_pend_i (has_pend),
    .gnt_i      (gnt_i),
    .mode_ro_i  (ras_only_i),
    .take_o     (take),
    .req_o      (req_o),
    .busy_o     (busy_o),
    .ras_n_o    (ras_n_o),
    .cas_n_o    (cas_n_o),
    .row_o      (row_addr_o),
    .addr_en_o  (addr_en_o)
  );

  assign we_n_o = 1'b1;
  assign oe_n_o = 1'b1;
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
  parameter int T_RAS = 6
) (
  input logic clk,
  input logic rst_n,
  input logic gnt_i,
  input logic req_o,
  input logic busy_o,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic we_n_o,
  input logic oe_n_o,
  input logic addr_en_o
);
  logic [15:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        lo_cnt <= '0;
    else if (!ras_n_o) lo_cnt <= lo_cnt + 1'b1;
    else               lo_cnt <= '0;
  end

  assert_cbr_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n_o) && !addr_en_o) |-> (!cas_n_o && $past(!cas_n_o)));

  assert_data_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (we_n_o && oe_n_o));

  assert_ro_cas_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_en_o |-> (cas_n_o && !ras_n_o));

  assert_ras_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_o) |-> (lo_cnt == 16'(T_RAS)));

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !gnt_i) |=> req_o);

  assert_idle_strobes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (ras_n_o && cas_n_o));

  assert_no_req_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !req_o);
endmodule

bind rfsh_sched rfsh_sched_chk #(.T_RAS(T_RAS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .gnt_i     (gnt_i),
  .req_o     (req_o),
  .busy_o    (busy_o),
  .ras_n_o   (ras_n_o),
  .cas_n_o   (cas_n_o),
  .we_n_o    (we_n_o),
  .oe_n_o    (oe_n_o),
  .addr_en_o (addr_en_o)
);

// File: tb/rfsh_sched_tb_top.sv
module rfsh_sched_tb_top;
  localparam int ROW_W    = 10;
  localparam int INTERVAL = 200;
  localparam int WINDOW   = INTERVAL * (1 << ROW_W);
  localparam int T_CSR    = 2;
  localparam int T_RAS    = 4;
  localparam int T_RP     = 3;
  localparam int T_CP     = 2;
  localparam int T_PRE    = (T_RP > T_CP) ? T_RP : T_CP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_only = 1'b0;
  logic gnt = 1'b0;
  logic req, busy, ras_n, cas_n, we_n, oe_n, aen;
  logic [ROW_W-1:0] row;

  always #5 clk = ~clk;

  rfsh_sched #(
    .ROW_W(ROW_W), .WINDOW_CYC(WINDOW), .PEND_MAX(8),
    .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ras_only_i(ras_only), .gnt_i(gnt),
    .req_o(req), .busy_o(busy), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .we_n_o(we_n), .oe_n_o(oe_n), .row_addr_o(row), .addr_en_o(aen)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int busy_falls = 0;
  int exp_burst = 1;
  int burst = 0;
  int last_fall = 0;
  int prev_fall = 0;
  int exp_row = 0;
  bit exp_ro_q[$];
  int exp_row_q[$];
  bit done = 1'b0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic push_cbr();
    exp_ro_q.push_back(1'b0);
    exp_row_q.push_back(0);
  endtask

  task automatic push_ro();
    exp_ro_q.push_back(1'b1);
    exp_row_q.push_back(exp_row);
    exp_row = (exp_row + 1) % (1 << ROW_W);
  endtask

  task automatic set_gnt(input bit v);
    @(posedge clk); #1 gnt = v;
  endtask

  task automatic wait_req();
    do @(negedge clk); while (!req);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor / scoreboard
  bit p_ras = 1, p_cas = 1, p_busy = 0, p_req = 0, p_gnt = 0, cur_cbr = 0;
  int ras_lo_run = 0, ras_hi_run = 0, cas_lo_run = 0, cas_hi_run = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !ras_n) begin
        burst++;
        prev_fall = last_fall;
        last_fall = cyc;
        cur_cbr = !cas_n;
        chk(busy, "R9 busy at RAS fall", busy, 1);
        chk(ras_hi_run >= T_RP, "R6 RAS precharge", ras_hi_run, T_RP);
        if (exp_ro_q.size() == 0) begin
          chk(1'b0, "R8 unexpected refresh", 1, 0);
        end else begin
          bit ero;
          int erow;
          ero = exp_ro_q.pop_front();
          erow = exp_row_q.pop_front();
          if (!ero) begin
            chk(!cas_n, "R2 CAS low at RAS fall", cas_n, 0);
            chk(cas_lo_run == T_CSR, "R2 CAS lead", cas_lo_run, T_CSR);
            chk(!aen, "R2 address not driven", aen, 0);
          end else begin
            chk(cas_n, "R4 CAS high in RAS-only", cas_n, 1);
            chk(aen, "R4 address enable", aen, 1);
            chk(int'(row) == erow, "R4 row address", row, erow);
          end
        end
      end
      if (!ras_n && !(p_ras && !ras_n))
        chk(cas_n == !cur_cbr, "R11 CAS held during RAS low", cas_n, !cur_cbr);
      if (!p_ras && ras_n)
        chk(ras_lo_run == T_RAS, "R5 RAS low width", ras_lo_run, T_RAS);
      if (p_cas && !cas_n)
        chk(cas_hi_run >= T_CP, "R6 CAS precharge", cas_hi_run, T_CP);
      if (p_busy && !busy) begin
        chk(ras_hi_run == T_PRE, "R6 precharge before release", ras_hi_run, T_PRE);
        chk(burst == exp_burst, "R8 burst length", burst, exp_burst);
        burst = 0;
        busy_falls++;
      end
      if (busy) chk(we_n && oe_n, "R3 WE/OE high", {we_n, oe_n}, 3);
      else      chk(ras_n && cas_n, "R9 idle strobes", {ras_n, cas_n}, 3);
      if (busy && req) chk(1'b0, "R9 req while busy", 1, 0);
      if (p_req && !p_gnt && !req) chk(1'b0, "R7 req dropped without grant", 0, 1);
      ras_lo_run = ras_n ? 0 : ras_lo_run + 1;
      ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
      cas_lo_run = (!cas_n && ras_n) ? cas_lo_run + 1 : 0;
      cas_hi_run = cas_n ? cas_hi_run + 1 : 0;
      p_ras = ras_n; p_cas = cas_n; p_busy = busy; p_req = req; p_gnt = gnt;
    end
  end

  // watchdog
  initial begin
    while (!done && cyc < 60000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", cyc, 60000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // driver
  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n, "R10 strobes in reset", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(!req && !busy && !aen, "R10 req/busy/aen in reset", {req, busy, aen}, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1 / R2: CAS-before-RAS singles with grant held
    exp_burst = 1;
    wait_req();
    push_cbr();
    set_gnt(1'b1);
    wait (busy_falls == 1);
    push_cbr();
    wait (busy_falls == 2);
    push_cbr();
    wait (busy_falls == 3);
    chk(last_fall - prev_fall == INTERVAL, "R1 CBR spacing", last_fall - prev_fall, INTERVAL);

    // R4: RAS-only rows from 0
    @(posedge clk); #1 ras_only = 1'b1;
    push_ro();
    wait (busy_falls == 4);
    push_ro();
    wait (busy_falls == 5);
    push_ro();
    wait (busy_falls == 6);
    chk(last_fall - prev_fall == INTERVAL, "R1 RAS-only spacing", last_fall - prev_fall, INTERVAL);

    // R11: mode flip mid-cycle takes effect next cycle
    push_ro();
    do @(negedge clk); while (ras_n);
    @(posedge clk); #1 ras_only = 1'b0;
    wait (busy_falls == 7);
    push_cbr();
    wait (busy_falls == 8);

    // R8: three pending RAS-only served back to back
    @(posedge clk); #1 gnt = 1'b0; ras_only = 1'b1;
    wait_req();
    repeat (3 * INTERVAL - INTERVAL / 2) @(posedge clk);
    push_ro(); push_ro(); push_ro();
    exp_burst = 3;
    set_gnt(1'b1);
    wait (busy_falls == 9);
    @(posedge clk); #1 gnt = 1'b0; ras_only = 1'b0;

    // R8: saturation at eight
    wait_req();
    repeat (11 * INTERVAL - INTERVAL / 2) @(posedge clk);
    for (int i = 0; i < 8; i++) push_cbr();
    exp_burst = 8;
    set_gnt(1'b1);
    wait (busy_falls == 10);
    @(posedge clk); #1 gnt = 1'b0;

    // excess requests were dropped: next one is a single
    wait_req();
    push_cbr();
    exp_burst = 1;
    set_gnt(1'b1);
    wait (busy_falls == 11);
    @(posedge clk); #1 gnt = 1'b0;
    repeat (5) @(negedge clk);
    chk(exp_ro_q.size() == 0, "R8 all expected refreshes seen", exp_ro_q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule